// File: doc/BRIEF.md
# ADC Scan Controller with Calibration

This block drives a multi-channel successive-approximation converter from a small register bus. Software picks channels through a bitmap, writes the start bit, and the controller walks the chosen channels from lowest to highest index. For each channel it hands a sample request to the external converter port. After a fixed conversion interval it takes the result and stores the 12-bit code in that channel's result register. When the last chosen channel is done, the busy flag drops and, if enabled, a one-cycle interrupt pulse is raised. Clearing the start bit while a scan runs halts the scan at once.

A separate calibration handshake lets software raise a request bit. It then waits for a ready flag, drops the request, and checks an error flag that holds its value until the next calibration begins. While a calibration request is pending, the controller does not accept a scan start.

The converter port uses two valid/ready channels. On the request channel, `conv_req_valid` and `conv_ch` stay unchanged until `conv_req_ready` is sampled high. On the result channel, the controller holds `conv_res_ready` low for the conversion interval. This is its back-pressure. It then holds it high until `conv_res_valid` arrives. A transfer happens on any clock edge where valid and ready are both high.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, every register reads 0x0000, and `irq`, `conv_req_valid` and `conv_res_ready` are low.
- R2: Writing the control word at 0x00 with bit 15 = 1 and bits 14:13 = 00 starts a scan. Bit 15 then reads 1 while the scan is busy. Each channel n whose bit n is set in the select word at 0x04 is requested exactly once, in ascending index order, with its index on `conv_ch`.
- R3: The result of channel n reads at 0x20 + 2n as a 12-bit code in bits 11:0, with bits 15:12 zero. Unselected channels keep their previous result.
- R4: `conv_req_valid` and `conv_ch` hold steady until `conv_req_ready`. After a request transfer, `conv_res_ready` stays low for exactly CONV_CYCLES cycles and then stays high until `conv_res_valid`. Request and result phases never overlap.
- R5: When the last selected channel has been stored, bit 15 clears. If control bit 12 is 1, `irq` pulses high for exactly one cycle. If bit 12 is 0, no pulse occurs.
- R6: Writing the control word with bit 15 = 0 during a scan aborts it. Bit 15 reads 0, no further request is issued, no interrupt fires, and channels not yet converted keep their old results.
- R7: A start with an all-zero select word finishes within two cycles, issues no request, and pulses `irq` if enabled.
- R8: A start write with bits 14:13 other than 00 starts nothing. Bit 15 stays 0, and the mode field reads back as written.
- R9: Changing the select word during a scan does not change the set of channels converted by that scan.
- R10: Setting bit 0 at 0x1F0 starts calibration. Bit 1 (ready) reads 1 from CAL_CYCLES+1 cycles after the write. At that moment bit 2 (error) captures `cal_err_in`. Clearing bit 0 clears ready one cycle later. The error bit keeps its value until the next calibration starts.
- R11: While calibration bit 0 is set, a scan start write is ignored.
- R12: Reads of any address other than the control, select, result and calibration words return 0, and so do odd addresses inside the result range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read enable; read data is combinational |
| bus_rdata | output | 16 | Read data, zero when bus_re is low |
| conv_req_valid | output | 1 | Sample request valid |
| conv_req_ready | input | 1 | Converter accepts the request |
| conv_ch | output | 4 | Channel index of the request |
| conv_res_valid | input | 1 | Converter result valid |
| conv_res_ready | output | 1 | Controller accepts the result |
| conv_res_data | input | 12 | Conversion code |
| cal_err_in | input | 1 | Calibration error status from the analog side |
| irq | output | 1 | End-of-scan interrupt pulse |

## Verification
The bench uses sparse bitmaps, including channels 0 and 15. A sequencer that skips the top index or goes in the wrong order would leave a result stale or change the request log. It aborts a scan while a request is stalled. A design that lets the held request complete afterwards would overwrite old results or pulse the interrupt. It rewrites the select word mid-scan, which catches a sequencer that reads the live bitmap instead of a snapshot. It times the result back-pressure window and the calibration ready edge to the cycle. It also checks that the calibration error bit survives the clearing of the request, which is exactly where a design that resets everything on request drop would lose the status.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int DATA_W   = 16;
  localparam int OFS_CTRL = 'h000;
  localparam int OFS_SEL  = 'h004;
  localparam int OFS_RES  = 'h020;
  localparam int OFS_CAL  = 'h1F0;

  localparam int CTRL_GO   = 15;
  localparam int CTRL_MHI  = 14;
  localparam int CTRL_MLO  = 13;
  localparam int CTRL_IE   = 12;

  localparam logic [1:0] MODE_SINGLE = 2'b00;

  typedef enum logic [1:0] {SQ_IDLE, SQ_PICK, SQ_REQ, SQ_WAIT} seq_state_e;
  typedef enum logic [1:0] {CL_IDLE, CL_RUN, CL_DONE} cal_state_e;
endpackage

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH         = 16,
  parameter int RES_W       = 12,
  parameter int CONV_CYCLES = 4,
  localparam int CH_W  = $clog2(NCH),
  localparam int CNT_W = $clog2(CONV_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [NCH-1:0]   sel,
  output logic             busy,
  output logic             done,
  output logic             conv_req_valid,
  input  logic             conv_req_ready,
  output logic [CH_W-1:0]  conv_ch,
  input  logic             conv_res_valid,
  output logic             conv_res_ready,
  input  logic [RES_W-1:0] conv_res_data,
  output logic             wr_en,
  output logic [CH_W-1:0]  wr_ch,
  output logic [RES_W-1:0] wr_data
);
  seq_state_e       st_q;
  logic [NCH-1:0]   left_q;
  logic [CH_W-1:0]  ch_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  nxt_ch;

  // lowest pending channel wins
  always_comb begin
    nxt_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (left_q[i]) nxt_ch = CH_W'(i);
    end
  end

  assign busy           = (st_q != SQ_IDLE);
  assign conv_req_valid = (st_q == SQ_REQ);
  assign conv_ch        = ch_q;
  assign conv_res_ready = (st_q == SQ_WAIT) && (cnt_q == '0);
  assign done           = (st_q == SQ_PICK) && (left_q == '0) && !abort;
  assign wr_en          = conv_res_ready && conv_res_valid && !abort;
  assign wr_ch          = ch_q;
  assign wr_data        = conv_res_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      left_q <= '0;
      ch_q   <= '0;
      cnt_q  <= '0;
    end else if (abort) begin
      st_q   <= SQ_IDLE;
      left_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start) begin
          left_q <= sel;
          st_q   <= SQ_PICK;
        end
        SQ_PICK: if (left_q == '0) begin
          st_q <= SQ_IDLE;
        end else begin
          ch_q           <= nxt_ch;
          left_q[nxt_ch] <= 1'b0;
          st_q           <= SQ_REQ;
        end
        SQ_REQ: if (conv_req_ready) begin
          cnt_q <= CNT_W'(CONV_CYCLES);
          st_q  <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (conv_res_valid) st_q <= SQ_PICK;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_cal_fsm.sv
module adc_cal_fsm
  import adc_scan_pkg::*;
#(
  parameter int CAL_CYCLES = 20,
  localparam int CW = $clog2(CAL_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic err_in,
  output logic ready,
  output logic err
);
  cal_state_e  st_q;
  logic [CW-1:0] cnt_q;
  logic        err_q;

  assign ready = (st_q == CL_DONE);
  assign err   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CL_IDLE;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      case (st_q)
        CL_IDLE: if (req) begin
          st_q  <= CL_RUN;
          cnt_q <= CW'(CAL_CYCLES - 1);
          err_q <= 1'b0;
        end
        CL_RUN: begin
          if (!req) st_q <= CL_IDLE;
          else if (cnt_q == '0) begin
            st_q  <= CL_DONE;
            err_q <= err_in;
          end else cnt_q <= cnt_q - 1'b1;
        end
        CL_DONE: if (!req) st_q <= CL_IDLE;
        default: st_q <= CL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NCH         = 16,
  parameter int RES_W       = 12,
  parameter int ADDR_W      = 9,
  parameter int CONV_CYCLES = 4,
  parameter int CAL_CYCLES  = 20,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              conv_req_valid,
  input  logic              conv_req_ready,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_res_valid,
  output logic              conv_res_ready,
  input  logic [RES_W-1:0]  conv_res_data,
  input  logic              cal_err_in,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_SEL     = ADDR_W'(OFS_SEL);
  localparam logic [ADDR_W-1:0] A_RES     = ADDR_W'(OFS_RES);
  localparam logic [ADDR_W-1:0] A_RES_END = ADDR_W'(OFS_RES + 2 * NCH);
  localparam logic [ADDR_W-1:0] A_CAL     = ADDR_W'(OFS_CAL);

  logic             ie_q, cal_req_q, irq_q;
  logic [1:0]       mode_q;
  logic [NCH-1:0]   sel_q;
  logic             busy, seq_done, wr_en;
  logic [CH_W-1:0]  wr_ch;
  logic [RES_W-1:0] wr_data;
  logic             cal_ready, cal_err;
  logic [NCH*RES_W-1:0] res_flat;

  logic wr_ctrl, start_go, abort_go;
  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  assign start_go = wr_ctrl && bus_wdata[CTRL_GO] && !busy && !cal_req_q
                    && (bus_wdata[CTRL_MHI:CTRL_MLO] == MODE_SINGLE);
  assign abort_go = wr_ctrl && !bus_wdata[CTRL_GO] && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q      <= 1'b0;
      mode_q    <= MODE_SINGLE;
      sel_q     <= '0;
      cal_req_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= seq_done && ie_q;
      if (wr_ctrl) begin
        ie_q   <= bus_wdata[CTRL_IE];
        mode_q <= bus_wdata[CTRL_MHI:CTRL_MLO];
      end
      if (bus_we && bus_addr == A_SEL) sel_q <= bus_wdata[NCH-1:0];
      if (bus_we && bus_addr == A_CAL) cal_req_q <= bus_wdata[0];
    end
  end
  assign irq = irq_q;

  for (genvar g = 0; g < NCH; g++) begin : g_res
    logic [RES_W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else if (wr_en && wr_ch == CH_W'(g)) r_q <= wr_data;
    end
    assign res_flat[g*RES_W +: RES_W] = r_q;
  end

  adc_scan_seq #(.NCH(NCH), .RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_go), .abort(abort_go), .sel(sel_q),
    .busy(busy), .done(seq_done),
    .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready), .conv_ch(conv_ch),
    .conv_res_valid(conv_res_valid), .conv_res_ready(conv_res_ready),
    .conv_res_data(conv_res_data),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data)
  );

  adc_cal_fsm #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk(clk), .rst_n(rst_n), .req(cal_req_q), .err_in(cal_err_in),
    .ready(cal_ready), .err(cal_err)
  );

  // register read path
  logic [ADDR_W-1:0] res_off;
  logic [CH_W-1:0]   res_idx;
  logic              res_hit;
  assign res_off = bus_addr - A_RES;
  assign res_idx = res_off[CH_W:1];
  assign res_hit = (bus_addr >= A_RES) && (bus_addr < A_RES_END) && !bus_addr[0];

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (bus_addr == A_CTRL)
        bus_rdata = {busy, mode_q, ie_q, 12'b0};
      else if (bus_addr == A_SEL)
        bus_rdata = DATA_W'(sel_q);
      else if (bus_addr == A_CAL)
        bus_rdata = {13'b0, cal_err, cal_ready, cal_req_q};
      else if (res_hit)
        bus_rdata = DATA_W'(res_flat[res_idx*RES_W +: RES_W]);
    end
  end
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            irq,
  input logic            ie_q,
  input logic            cal_req_q,
  input logic            conv_req_valid,
  input logic            conv_req_ready,
  input logic [CH_W-1:0] conv_ch,
  input logic            conv_res_ready
);
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r5_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ie_q));

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_valid && !conv_req_ready) |=> (!busy || (conv_req_valid && $stable(conv_ch))));

  a_r4_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    conv_res_ready |-> !conv_req_valid);

  a_r11_no_start_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cal_req_q));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .ie_q(ie_q),
  .cal_req_q(cal_req_q), .conv_req_valid(conv_req_valid),
  .conv_req_ready(conv_req_ready), .conv_ch(conv_ch),
  .conv_res_ready(conv_res_ready)
);

// File: tb/adc_scan_ctrl_test.sv
`timescale 1ns/1ps
module adc_scan_ctrl_test;
  localparam int CONV = 4;
  localparam int CALC = 20;
  localparam logic [8:0] A_CTRL = 9'h000, A_SEL = 9'h004, A_CAL = 9'h1F0;

  logic clk = 0, rst_n = 0;
  logic [8:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic bus_we = 0, bus_re = 0;
  logic conv_req_valid, conv_req_ready, conv_res_valid, conv_res_ready, irq;
  logic [3:0]  conv_ch;
  logic [11:0] conv_res_data;
  logic cal_err_in = 0;

  always #5 clk = ~clk;

  adc_scan_ctrl #(.CONV_CYCLES(CONV), .CAL_CYCLES(CALC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready), .conv_ch(conv_ch),
    .conv_res_valid(conv_res_valid), .conv_res_ready(conv_res_ready),
    .conv_res_data(conv_res_data), .cal_err_in(cal_err_in), .irq(irq)
  );

  int checks = 0, errors = 0;
  logic [11:0] exp_res [16];

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
    end
  endtask

  function automatic logic [11:0] code(input int ch, input int s);
    return 12'((ch * 273 + s) & 12'hFFF);
  endfunction

  // converter model, acting on falling edges
  logic stall = 0;
  int salt = 0, n_log = 0, low_cnt = 0, last_wait = -1, pend_ch = 0, fire_ch = 0;
  int log_ch [64];
  bit pending = 0, req_fire = 0, res_fire = 0;
  initial begin
    conv_req_ready = 0; conv_res_valid = 0; conv_res_data = '0;
    forever begin
      @(negedge clk);
      if (res_fire) begin pending = 0; last_wait = low_cnt; end
      if (req_fire) begin
        pending = 1; pend_ch = fire_ch; low_cnt = 0;
        if (n_log < 64) log_ch[n_log] = fire_ch;
        n_log++;
      end
      conv_req_ready = conv_req_valid && !stall && !pending;
      conv_res_valid = pending;
      conv_res_data  = code(pend_ch, salt);
      if (pending && !conv_res_ready) low_cnt++;
      req_fire = conv_req_valid && conv_req_ready;
      fire_ch  = int'(conv_ch);
      res_fire = conv_res_valid && conv_res_ready;
    end
  end

  task automatic bus_write(input logic [8:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [15:0] d);
    #1; bus_addr = a; bus_re = 1;
    #1; d = bus_rdata; bus_re = 0;
  endtask

  function automatic logic [8:0] res_addr(input int ch);
    return 9'(32 + 2 * ch);
  endfunction

  task automatic check_results(input string req);
    logic [15:0] rd;
    for (int c = 0; c < 16; c++) begin
      bus_read(res_addr(c), rd);
      check(rd == {4'b0, exp_res[c]}, req, rd, {4'b0, exp_res[c]});
    end
  endtask

  // waits until busy clears, returns number of irq cycles seen
  task automatic wait_idle(output int irqs);
    logic [15:0] rd;
    irqs = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      if (irq) irqs++;
      bus_read(A_CTRL, rd);
      if (!rd[15]) break;
    end
    repeat (3) begin @(posedge clk); #1; if (irq) irqs++; end
  endtask

  task automatic t_reset;
    logic [15:0] rd;
    bus_read(A_CTRL, rd); check(rd == 0, "R1 ctrl", rd, 0);
    bus_read(A_SEL, rd);  check(rd == 0, "R1 sel", rd, 0);
    bus_read(A_CAL, rd);  check(rd == 0, "R1 cal", rd, 0);
    bus_read(res_addr(7), rd); check(rd == 0, "R1 result", rd, 0);
    check(!irq && !conv_req_valid && !conv_res_ready, "R1 outputs", {irq, conv_req_valid, conv_res_ready}, 0);
  endtask

  task automatic t_scan(input logic [15:0] sel, input bit ie, input int s);
    logic [15:0] rd;
    int irqs, k, n0;
    salt = s; n0 = n_log;
    bus_write(A_SEL, sel);
    bus_write(A_CTRL, {1'b1, 2'b00, ie, 12'b0});
    bus_read(A_CTRL, rd);
    check(rd[15] == 1'b1, "R2 busy reads 1", rd[15], 1);
    wait_idle(irqs);
    check(irqs == (ie ? 1 : 0), "R5 irq pulse count", irqs, ie ? 1 : 0);
    k = n0;
    for (int c = 0; c < 16; c++) begin
      if (sel[c]) begin
        check(k < n_log && log_ch[k] == c, "R2 ascending order", (k < n_log) ? log_ch[k] : -1, c);
        exp_res[c] = code(c, s);
        k++;
      end
    end
    check(k == n_log, "R2 request count", n_log - n0, k - n0);
    if (sel != 0) check(last_wait == CONV, "R4 result back-pressure", last_wait, CONV);
    check_results("R3 results");
  endtask

  task automatic t_empty;
    int irqs, n0;
    n0 = n_log;
    bus_write(A_SEL, 16'h0000);
    bus_write(A_CTRL, 16'h9000);
    wait_idle(irqs);
    check(irqs == 1, "R7 empty scan irq", irqs, 1);
    check(n_log == n0, "R7 no requests", n_log - n0, 0);
  endtask

  task automatic t_mode;
    logic [15:0] rd;
    int n0;
    n0 = n_log;
    bus_write(A_SEL, 16'h0001);
    bus_write(A_CTRL, 16'hA000);
    bus_read(A_CTRL, rd);
    check(rd == 16'h2000, "R8 mode readback no busy", rd, 16'h2000);
    repeat (10) @(posedge clk); #1;
    check(n_log == n0, "R8 no requests", n_log - n0, 0);
  endtask

  task automatic t_abort;
    logic [15:0] rd;
    int irqs = 0, reqs = 0;
    salt = 77; stall = 1;
    bus_write(A_SEL, 16'h0003);
    bus_write(A_CTRL, 16'h9000);
    repeat (5) @(posedge clk); #1;
    check(conv_req_valid && conv_ch == 0, "R4 request held while stalled", {conv_req_valid, conv_ch}, 16);
    bus_write(A_CTRL, 16'h1000);
    bus_read(A_CTRL, rd);
    check(rd[15] == 1'b0, "R6 busy cleared", rd[15], 0);
    repeat (12) begin
      @(posedge clk); #1;
      if (irq) irqs++;
      if (conv_req_valid) reqs++;
    end
    check(irqs == 0, "R6 no irq", irqs, 0);
    check(reqs == 0, "R6 no request", reqs, 0);
    stall = 0;
    check_results("R6 results kept");
  endtask

  task automatic t_sel_change;
    int irqs, n0;
    n0 = n_log; salt = 300;
    bus_write(A_SEL, 16'h0030);
    bus_write(A_CTRL, 16'h9000);
    bus_write(A_SEL, 16'h0001);
    wait_idle(irqs);
    check(n_log - n0 == 2 && log_ch[n0] == 4 && log_ch[n0+1] == 5, "R9 snapshot of bitmap",
          n_log - n0, 2);
    exp_res[4] = code(4, 300); exp_res[5] = code(5, 300);
    check_results("R9 results");
  endtask

  task automatic t_cal;
    logic [15:0] rd;
    int n0;
    bus_write(A_SEL, 16'h0001);
    cal_err_in = 0;
    bus_write(A_CAL, 16'h0001);
    repeat (CALC) @(posedge clk);
    bus_read(A_CAL, rd); check(rd == 16'h0001, "R10 not ready early", rd, 1);
    @(posedge clk);
    bus_read(A_CAL, rd); check(rd == 16'h0003, "R10 ready on time", rd, 3);
    n0 = n_log;
    bus_write(A_CTRL, 16'h9000);
    bus_read(A_CTRL, rd); check(rd[15] == 1'b0, "R11 start ignored in cal", rd[15], 0);
    repeat (8) @(posedge clk);
    check(n_log == n0, "R11 no requests", n_log - n0, 0);
    bus_write(A_CAL, 16'h0000);
    @(posedge clk);
    bus_read(A_CAL, rd); check(rd == 16'h0000, "R10 ready clears", rd, 0);
    cal_err_in = 1;
    bus_write(A_CAL, 16'h0001);
    repeat (CALC + 1) @(posedge clk);
    bus_read(A_CAL, rd); check(rd == 16'h0007, "R10 error captured", rd, 7);
    cal_err_in = 0;
    bus_write(A_CAL, 16'h0000);
    @(posedge clk);
    bus_read(A_CAL, rd); check(rd == 16'h0004, "R10 error persists", rd, 4);
    bus_write(A_CAL, 16'h0001);
    @(posedge clk);
    bus_read(A_CAL, rd); check(rd == 16'h0001, "R10 error cleared on new run", rd, 1);
    bus_write(A_CAL, 16'h0000);
    @(posedge clk);
  endtask

  task automatic t_unused;
    logic [15:0] rd;
    logic [8:0] addrs [5] = '{9'h002, 9'h008, 9'h021, 9'h040, 9'h1F2};
    foreach (addrs[i]) begin
      bus_read(addrs[i], rd);
      check(rd == 0, "R12 unused read", rd, 0);
    end
  endtask

  bit timed_out = 0;
  initial begin
    #2_000_000;
    timed_out = 1;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 16; c++) exp_res[c] = '0;
    repeat (3) @(posedge clk); #1;
    t_reset();
    rst_n = 1;
    t_scan(16'h8425, 1'b1, 5);
    t_scan(16'h00C3, 1'b0, 900);
    t_scan(16'hFFFF, 1'b1, 2001);
    t_empty();
    t_mode();
    t_abort();
    t_sel_change();
    t_cal();
    t_unused();
    if (!timed_out) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule